// File: doc/BRIEF.md
# Boot-Time Address Overlay Controller

This block sits between a 16-bit big-endian processor bus with a 24-bit byte address and a local bus with a 22-bit byte address. After any reset it forces every processor access into the boot ROM window at the top of the local space. It keeps the low 19 address bits and drives the upper local bits to the window base, so the processor fetches its vectors and start-up code from ROM whatever address it puts out.

Software leaves the overlay in two steps. First it writes any value to the arm register, which sits at local byte address 0x3F5000 as seen after translation. Then it makes a read or a write whose processor address bit 23 is zero. That access, and every access after it, goes through untranslated until the next reset. Accesses flagged as debug, which have no side effects, never end the overlay.

Strobes, byte lanes, direction and write data are carried to the local bus through one register stage. Read data comes back with a registered ready one cycle after the local strobe is seen.

Top module: `boot_overlay_ctrl`

## Requirements
- R1: While `rst` or `cpu_reset` is high, the block sets `overlay_active` to 1 and `init_armed` to 0 on the next clock edge.
- R2: When an access begins while the overlay is active and the exit condition is not met, the local address is `(cpu_addr & 0x07FFFF) | 0x380000`.
- R3: An access with `cpu_addr[23]==0` does not end the overlay unless `init_armed` was already 1 when the access began.
- R4: A write (`cpu_rw`=0) whose translated local address has bits [21:1] equal to 0x3F5000>>1 sets `init_armed`, whatever the write data. A second such write leaves both flags unchanged.
- R5: An access with `dbg_access`=1 never clears `overlay_active`.
- R6: While `overlay_active`=1 and `init_armed`=1, a non-debug access that begins with `cpu_addr[23]==0` clears `overlay_active`. That access is itself not translated (local address = `cpu_addr[21:0]`). Reads and writes both qualify.
- R7: While the overlay is inactive, the local address is `cpu_addr & 0x3FFFFF`, and `overlay_active` stays 0 until a reset.
- R8: `loc_as`, `loc_rw`, `loc_uds`, `loc_lds` and `loc_wdata` equal the processor inputs one clock later. `cpu_ready` is high one clock after `loc_as`, and `cpu_rdata` then holds the `loc_rdata` captured on that edge.
- R9: `init_armed` stays 1 until a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high |
| cpu_reset | input | 1 | Processor reset output, active high; re-enters the overlay |
| dbg_access | input | 1 | Marks the current access as side-effect free |
| cpu_as | input | 1 | Processor access strobe, active high |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_uds | input | 1 | Upper byte lane strobe |
| cpu_lds | input | 1 | Lower byte lane strobe |
| cpu_addr | input | 24 | Processor byte address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Registered read data toward the processor |
| cpu_ready | output | 1 | Registered access ready |
| loc_as | output | 1 | Local access strobe |
| loc_rw | output | 1 | Local direction |
| loc_uds | output | 1 | Local upper byte lane strobe |
| loc_lds | output | 1 | Local lower byte lane strobe |
| loc_addr | output | 22 | Translated local byte address |
| loc_wdata | output | 16 | Local write data |
| loc_rdata | input | 16 | Local read data |
| overlay_active | output | 1 | Overlay flag |
| init_armed | output | 1 | Arm flag |

## Verification
The bench targets the exit sequence. It makes a low-half access before arming, which a design exiting on bit 23 alone would wrongly accept. It makes a debug access while armed, which a design ignoring the debug input would use to leave the overlay. It also checks the exiting access itself, which a design using the stale flag for translation would remap into the ROM window. A processor reset after exit must put the overlay back and clear the arm flag, or later fetches would miss the ROM. An exit through a write confirms that direction plays no part.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int CPU_AW_D   = 24;
  localparam int LOC_AW_D   = 22;
  localparam int DW_D       = 16;
  localparam int KEEP_W_D   = 19;
  localparam logic [21:0] ROM_BASE_D = 22'h380000;
  localparam logic [21:0] ARM_ADDR_D = 22'h3F5000;
endpackage

// File: rtl/ovl_xlate.sv
module ovl_xlate #(
  parameter int CPU_AW = 24,
  parameter int LOC_AW = 22,
  parameter int KEEP_W = 19,
  parameter logic [LOC_AW-1:0] ROM_BASE = '0
) (
  input  logic [CPU_AW-1:0] addr_in,
  input  logic              remap,
  output logic [LOC_AW-1:0] addr_out
);
  localparam logic [LOC_AW-1:0] KEEP_MASK = LOC_AW'((64'd1 << KEEP_W) - 64'd1);

  logic [LOC_AW-1:0] trunc;
  assign trunc = addr_in[LOC_AW-1:0];

  always_comb begin
    if (remap) addr_out = (trunc & KEEP_MASK) | ROM_BASE;
    else       addr_out = trunc;
  end
endmodule

// File: rtl/ovl_state.sv
module ovl_state #(
  parameter int LOC_AW = 22,
  parameter logic [LOC_AW-1:0] ARM_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_reset,
  input  logic              start,
  input  logic              is_read,
  input  logic              dbg,
  input  logic              top_bit,
  input  logic [LOC_AW-1:0] next_addr,
  output logic              active,
  output logic              armed,
  output logic              exit_now
);
  logic hit_arm;

  assign exit_now = start && active && armed && !top_bit && !dbg;
  assign hit_arm  = start && !is_read && (next_addr[LOC_AW-1:1] == ARM_ADDR[LOC_AW-1:1]);

  always_ff @(posedge clk) begin
    if (rst || cpu_reset) begin
      active <= 1'b1;
      armed  <= 1'b0;
    end else begin
      if (exit_now) active <= 1'b0;
      if (hit_arm)  armed  <= 1'b1;
    end
  end
endmodule

// File: rtl/ovl_busreg.sv
module ovl_busreg #(
  parameter int LOC_AW = 22,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_as,
  input  logic              in_rw,
  input  logic              in_uds,
  input  logic              in_lds,
  input  logic [LOC_AW-1:0] in_addr,
  input  logic [DW-1:0]     in_wdata,
  input  logic [DW-1:0]     ret_data,
  output logic              out_as,
  output logic              out_rw,
  output logic              out_uds,
  output logic              out_lds,
  output logic [LOC_AW-1:0] out_addr,
  output logic [DW-1:0]     out_wdata,
  output logic              ready,
  output logic [DW-1:0]     rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_as    <= 1'b0;
      out_rw    <= 1'b1;
      out_uds   <= 1'b0;
      out_lds   <= 1'b0;
      out_addr  <= '0;
      out_wdata <= '0;
      ready     <= 1'b0;
      rdata     <= '0;
    end else begin
      out_as    <= in_as;
      out_rw    <= in_rw;
      out_uds   <= in_uds;
      out_lds   <= in_lds;
      out_addr  <= in_addr;
      out_wdata <= in_wdata;
      ready     <= out_as;
      rdata     <= ret_data;
    end
  end
endmodule

// File: rtl/boot_overlay_ctrl.sv
module boot_overlay_ctrl
  import ovl_pkg::*;
#(
  parameter int CPU_AW = CPU_AW_D,
  parameter int LOC_AW = LOC_AW_D,
  parameter int DW     = DW_D,
  parameter int KEEP_W = KEEP_W_D,
  parameter logic [LOC_AW-1:0] ROM_BASE = ROM_BASE_D,
  parameter logic [LOC_AW-1:0] ARM_ADDR = ARM_ADDR_D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_reset,
  input  logic              dbg_access,
  input  logic              cpu_as,
  input  logic              cpu_rw,
  input  logic              cpu_uds,
  input  logic              cpu_lds,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     cpu_rdata,
  output logic              cpu_ready,
  output logic              loc_as,
  output logic              loc_rw,
  output logic              loc_uds,
  output logic              loc_lds,
  output logic [LOC_AW-1:0] loc_addr,
  output logic [DW-1:0]     loc_wdata,
  input  logic [DW-1:0]     loc_rdata,
  output logic              overlay_active,
  output logic              init_armed
);
  logic              start;
  logic              exit_now;
  logic              remap;
  logic [LOC_AW-1:0] next_addr;

  assign start = cpu_as && !loc_as;
  assign remap = overlay_active && !exit_now;

  ovl_xlate #(
    .CPU_AW(CPU_AW), .LOC_AW(LOC_AW), .KEEP_W(KEEP_W), .ROM_BASE(ROM_BASE)
  ) u_xlate (
    .addr_in(cpu_addr), .remap(remap), .addr_out(next_addr)
  );

  ovl_state #(
    .LOC_AW(LOC_AW), .ARM_ADDR(ARM_ADDR)
  ) u_state (
    .clk(clk), .rst(rst), .cpu_reset(cpu_reset), .start(start),
    .is_read(cpu_rw), .dbg(dbg_access), .top_bit(cpu_addr[CPU_AW-1]),
    .next_addr(next_addr), .active(overlay_active), .armed(init_armed),
    .exit_now(exit_now)
  );

  ovl_busreg #(
    .LOC_AW(LOC_AW), .DW(DW)
  ) u_bus (
    .clk(clk), .rst(rst), .in_as(cpu_as), .in_rw(cpu_rw), .in_uds(cpu_uds),
    .in_lds(cpu_lds), .in_addr(next_addr), .in_wdata(cpu_wdata),
    .ret_data(loc_rdata), .out_as(loc_as), .out_rw(loc_rw), .out_uds(loc_uds),
    .out_lds(loc_lds), .out_addr(loc_addr), .out_wdata(loc_wdata),
    .ready(cpu_ready), .rdata(cpu_rdata)
  );
endmodule

// File: rtl/ovl_checker.sv
module ovl_checker #(
  parameter int LOC_AW = 22,
  parameter int KEEP_W = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_reset,
  input logic              dbg_access,
  input logic              loc_as,
  input logic [LOC_AW-1:0] loc_addr,
  input logic              cpu_ready,
  input logic              overlay_active,
  input logic              init_armed
);
  p_reset_state_r1: assert property (@(posedge clk)
    (rst || cpu_reset) |=> (overlay_active && !init_armed));

  p_remap_window_r2: assert property (@(posedge clk) disable iff (rst || cpu_reset)
    (loc_as && overlay_active && $past(overlay_active)) |-> (&loc_addr[LOC_AW-1:KEEP_W]));

  p_debug_keeps_r5: assert property (@(posedge clk) disable iff (rst)
    (overlay_active && dbg_access) |=> overlay_active);

  p_no_reentry_r7: assert property (@(posedge clk) disable iff (rst || cpu_reset)
    !overlay_active |=> !overlay_active);

  p_ready_follows_r8: assert property (@(posedge clk) disable iff (rst)
    loc_as |=> cpu_ready);

  p_arm_sticky_r9: assert property (@(posedge clk) disable iff (rst || cpu_reset)
    init_armed |=> init_armed);
endmodule

bind boot_overlay_ctrl ovl_checker #(.LOC_AW(LOC_AW), .KEEP_W(KEEP_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_reset(cpu_reset), .dbg_access(dbg_access),
  .loc_as(loc_as), .loc_addr(loc_addr), .cpu_ready(cpu_ready),
  .overlay_active(overlay_active), .init_armed(init_armed)
);

// File: tb/sim_boot_overlay_ctrl.sv
module sim_boot_overlay_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_reset = 1'b0;
  logic        dbg_access = 1'b0;
  logic        cpu_as = 1'b0;
  logic        cpu_rw = 1'b1;
  logic        cpu_uds = 1'b0;
  logic        cpu_lds = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        cpu_ready;
  logic        loc_as, loc_rw, loc_uds, loc_lds;
  logic [21:0] loc_addr;
  logic [15:0] loc_wdata;
  logic [15:0] loc_rdata = 16'h0;
  logic        overlay_active, init_armed;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected item: {rw, uds, lds, wdata, addr}
  logic [40:0] sb_q[$];
  logic        m_act, m_arm;
  logic        prev_as = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_overlay_ctrl u0 (
    .clk(clk), .rst(rst), .cpu_reset(cpu_reset), .dbg_access(dbg_access),
    .cpu_as(cpu_as), .cpu_rw(cpu_rw), .cpu_uds(cpu_uds), .cpu_lds(cpu_lds),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .loc_as(loc_as), .loc_rw(loc_rw), .loc_uds(loc_uds),
    .loc_lds(loc_lds), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
    .loc_rdata(loc_rdata), .overlay_active(overlay_active), .init_armed(init_armed)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item at the first cycle of each local access
  always @(negedge clk) begin
    if (loc_as && !prev_as) begin
      if (sb_q.size() == 0) check("R8 unexpected access", 32'd1, 32'd0);
      else begin
        logic [40:0] e;
        e = sb_q.pop_front();
        check("R2/R6/R7 loc_addr", {10'd0, loc_addr}, {10'd0, e[21:0]});
        check("R8 lanes/dir/wdata", {13'd0, loc_rw, loc_uds, loc_lds, loc_wdata},
              {13'd0, e[40:38], e[37:22]});
      end
    end
    prev_as = loc_as;
  end

  // driver: model computes expected translation and flag updates
  task automatic access(input logic [23:0] a, input bit rd, input bit dbg,
                        input logic [15:0] wd, input logic [1:0] lanes);
    logic exitc, remap;
    logic [21:0] ea;
    @(negedge clk);
    exitc = m_act && m_arm && !a[23] && !dbg;
    remap = m_act && !exitc;
    ea = remap ? ((a[21:0] & 22'h07FFFF) | 22'h380000) : a[21:0];
    if (exitc) m_act = 1'b0;
    if (!rd && ea[21:1] == 21'h1FA800) m_arm = 1'b1;
    sb_q.push_back({rd, lanes, wd, ea});
    cpu_addr = a; cpu_rw = rd; dbg_access = dbg; cpu_wdata = wd;
    {cpu_uds, cpu_lds} = lanes; cpu_as = 1'b1;
    loc_rdata = a[15:0] ^ 16'h5A5A;
    @(negedge clk);
    @(negedge clk);
    check("R8 ready", {31'd0, cpu_ready}, 32'd1);
    if (rd) check("R8 rdata", {16'd0, cpu_rdata}, {16'd0, a[15:0] ^ 16'h5A5A});
    cpu_as = 1'b0; dbg_access = 1'b0;
    @(negedge clk);
  endtask

  task automatic flags(input string req);
    check(req, {30'd0, overlay_active, init_armed}, {30'd0, m_act, m_arm});
  endtask

  initial begin
    m_act = 1'b1; m_arm = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset state", {30'd0, overlay_active, init_armed}, 32'd2);
    // R2 translation with several patterns
    access(24'h000100, 1, 0, 16'h0, 2'b11);
    access(24'hABCDEE, 1, 0, 16'h0, 2'b10);
    access(24'h7FFFFE, 0, 0, 16'h1234, 2'b01);
    // R3 low-half access while unarmed keeps overlay
    access(24'h012340, 1, 0, 16'h0, 2'b11);
    flags("R3 no exit when unarmed");
    check("R3 still active", {31'd0, overlay_active}, 32'd1);
    // R4 arm with a write landing on 0x3F5000 after translation
    access(24'hF75000, 0, 0, 16'hDEAD, 2'b11);
    check("R4 armed", {31'd0, init_armed}, 32'd1);
    flags("R4 flags after arm");
    // R4 second arm write, other data value, no further effect
    access(24'hF75000, 0, 0, 16'h0000, 2'b11);
    flags("R4 second arm write");
    // R5 debug access in low half does not exit
    access(24'h001000, 1, 1, 16'h0, 2'b11);
    check("R5 debug no exit", {31'd0, overlay_active}, 32'd1);
    // R3 armed but bit 23 set: still translated
    access(24'h801000, 1, 0, 16'h0, 2'b11);
    check("R3 high half keeps overlay", {31'd0, overlay_active}, 32'd1);
    // R6 exit access itself untranslated
    access(24'h001234, 1, 0, 16'h0, 2'b11);
    check("R6 exited", {31'd0, overlay_active}, 32'd0);
    // R7 pass-through truncation
    access(24'hC12346, 1, 0, 16'h0, 2'b11);
    access(24'h3F5000, 0, 0, 16'h0042, 2'b01);
    flags("R7 stays inactive, R9 armed kept");
    // R1 processor reset reenters overlay
    @(negedge clk); cpu_reset = 1'b1;
    @(negedge clk); cpu_reset = 1'b0;
    m_act = 1'b1; m_arm = 1'b0;
    flags("R1 cpu_reset state");
    access(24'h000200, 1, 0, 16'h0, 2'b11);
    check("R9 arm cleared only by reset", {31'd0, init_armed}, 32'd0);
    // R6 exit via write
    access(24'hF75001, 0, 0, 16'h7777, 2'b11);
    access(24'h020000, 0, 0, 16'hBEEF, 2'b10);
    check("R6 write exit", {31'd0, overlay_active}, 32'd0);
    access(24'h020002, 1, 0, 16'h0, 2'b11);
    repeat (2) @(negedge clk);
    check("R8 queue drained", sb_q.size(), 32'd0);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule